// File: doc/BRIEF.md
# Block-Based Pattern Sequencer

This block plays a user pattern held in an on-chip word memory as an ordered list of up to four blocks. Each block is given by a base word address and a length counted in memory words. A memory word is one 512-bit granule by default. Blocks play in ascending index order, from block 0 up to a programmed last block index. One contiguous range of blocks can be repeated as a loop. The loop either runs a programmed number of extra passes or repeats without end. Only one loop level exists.

Playback starts on a one-cycle command pulse or on a rising edge at an asynchronous auxiliary input, which passes through a two-flop synchronizer first. While a sequence is running the block presents one read address per cycle and reports which block that address belongs to. The memory returns the addressed word one cycle later. When the final block has finished, the busy flag drops and the done flag rises. After that the data output stays at zero until a new start is accepted.

The memory is written through a simple write port and is read only by the sequencer.

Top module: `patseq_top`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, `pat_o` is all zeros and `rd_addr_o` is 0.
- R2: A `start_i` that is high at a clock edge while idle makes `busy_o` 1 and clears `done_o` from that edge. In the first busy cycle the block index is 0 and the address is the first word of block 0.
- R3: A rising edge on `aux_i` starts playback exactly like `start_i`, but the start is accepted at the third clock edge after `aux_i` goes high. Holding `aux_i` high does not start playback again.
- R4: Blocks play in index order 0..`last_blk_i`. A block with base B and length L presents addresses B, B+1, ..., B+L-1 (modulo the memory depth), one per cycle with no gaps. Block k's base sits in bits [k*ADDR_W +: ADDR_W] of `blk_base_i` and its length in bits [k*LEN_W +: LEN_W] of `blk_len_i`.
- R5: `pat_o` carries the memory word at the address presented one cycle earlier. It is all zeros in a cycle that follows a cycle with no address presented.
- R6: A block of length 0 plays no words. It takes exactly one cycle, in which `rd_addr_o` is 0 and `blk_idx_o` shows that block.
- R7: After the last word of block `loop_last_i`, playback jumps back to block `loop_first_i` until the range has played `loop_cnt_i`+1 times in all. It then continues with the block after `loop_last_i`. The bench keeps `loop_first_i` ≤ `loop_last_i` ≤ `last_blk_i`.
- R8: With `loop_inf_i` high the loop range repeats without end, and `done_o` never rises.
- R9: On the edge after the last word of block `last_blk_i`, `busy_o` falls and `done_o` rises together. `done_o` then stays high, and `busy_o` and `done_o` are never both high.
- R10: A start from either source that arrives while busy is ignored, and playback continues unchanged.
- R11: `blk_idx_o` shows the index of the block to which the current cycle's address belongs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Memory write enable |
| wr_addr_i | input | ADDR_W | Memory write word address |
| wr_data_i | input | WORD_W | Memory write data |
| blk_base_i | input | 4*ADDR_W | Base word address of each block |
| blk_len_i | input | 4*LEN_W | Length of each block in words |
| last_blk_i | input | 2 | Index of the final block in the sequence |
| loop_first_i | input | 2 | First block of the loop range |
| loop_last_i | input | 2 | Last block of the loop range |
| loop_cnt_i | input | CNT_W | Extra passes of the loop range |
| loop_inf_i | input | 1 | Repeat the loop range without end |
| start_i | input | 1 | Synchronous start command |
| aux_i | input | 1 | Asynchronous auxiliary start input |
| rd_addr_o | output | ADDR_W | Word address read this cycle |
| blk_idx_o | output | 2 | Block of the current address |
| pat_o | output | WORD_W | Pattern word output |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Sequence finished |

## Verification
The bench builds the block with 16-bit words, a 32-word memory, 3-bit block lengths and a 2-bit loop count. This keeps a full sequence down to a few dozen cycles. It also makes it possible to sweep every legal loop range across all four blocks, with every loop count from 0 to 3, and to vary the last block index. The small sizes bring within reach the mixes of zero-length blocks, aux-triggered starts, starts during playback and an endless loop. The expected address stream is rebuilt in the bench from the block list, and each memory word is an arithmetic function of its address.

// File: rtl/patseq_pkg.sv
package patseq_pkg;
  localparam int NBLK  = 4;
  localparam int BLK_W = $clog2(NBLK);
  typedef logic [BLK_W-1:0] blk_t;
endpackage

// File: rtl/patseq_sync.sv
module patseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/patseq_ram.sv
module patseq_ram #(
  parameter int WORD_W = 512,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Output register: idle cycles return zeros
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
    else         rdata <= '0;
  end
endmodule

// File: rtl/patseq_ctrl.sv
module patseq_ctrl
  import patseq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LEN_W  = 4,
  parameter int CNT_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NBLK*ADDR_W-1:0] blk_base,
  input  logic [NBLK*LEN_W-1:0]  blk_len,
  input  blk_t                   last_blk,
  input  blk_t                   loop_first,
  input  blk_t                   loop_last,
  input  logic [CNT_W-1:0]       loop_cnt,
  input  logic                   loop_inf,
  output logic                   rd_en,
  output logic [ADDR_W-1:0]      rd_addr,
  output blk_t                   blk_idx,
  output logic                   busy,
  output logic                   done
);
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  blk_t             blk_q, blk_d;
  logic [LEN_W-1:0] off_q, off_d;
  logic [CNT_W-1:0] pass_q, pass_d;

  logic [LEN_W-1:0]  cur_len;
  logic [ADDR_W-1:0] cur_base;
  logic              blk_end;
  logic              loop_back;

  always_comb begin
    cur_len   = blk_len[blk_q*LEN_W +: LEN_W];
    cur_base  = blk_base[blk_q*ADDR_W +: ADDR_W];
    blk_end   = (cur_len == '0) || (off_q == cur_len - LEN_W'(1));
    loop_back = (blk_q == loop_last) && (loop_inf || (pass_q != loop_cnt));
  end

  // Next-state logic
  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    blk_d  = blk_q;
    off_d  = off_q;
    pass_d = pass_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        done_d = 1'b0;
        blk_d  = '0;
        off_d  = '0;
        pass_d = '0;
      end
    end else if (blk_end) begin
      off_d = '0;
      if (loop_back) begin
        blk_d = loop_first;
        if (!loop_inf) pass_d = pass_q + CNT_W'(1);
      end else if (blk_q == last_blk) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        blk_d = blk_q + BLK_W'(1);
      end
    end else begin
      off_d = off_q + LEN_W'(1);
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      blk_q  <= '0;
      off_q  <= '0;
      pass_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      blk_q  <= blk_d;
      off_q  <= off_d;
      pass_q <= pass_d;
    end
  end

  assign rd_en   = busy_q && (cur_len != '0);
  assign rd_addr = rd_en ? cur_base + ADDR_W'(off_q) : '0;
  assign blk_idx = blk_q;
  assign busy    = busy_q;
  assign done    = done_q;
endmodule

// File: rtl/patseq_top.sv
module patseq_top
  import patseq_pkg::*;
#(
  parameter int WORD_W = 512,
  parameter int DEPTH  = 64,
  parameter int LEN_W  = 4,
  parameter int CNT_W  = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [WORD_W-1:0]      wr_data_i,
  input  logic [NBLK*ADDR_W-1:0] blk_base_i,
  input  logic [NBLK*LEN_W-1:0]  blk_len_i,
  input  logic [BLK_W-1:0]       last_blk_i,
  input  logic [BLK_W-1:0]       loop_first_i,
  input  logic [BLK_W-1:0]       loop_last_i,
  input  logic [CNT_W-1:0]       loop_cnt_i,
  input  logic                   loop_inf_i,
  input  logic                   start_i,
  input  logic                   aux_i,
  output logic [ADDR_W-1:0]      rd_addr_o,
  output logic [BLK_W-1:0]       blk_idx_o,
  output logic [WORD_W-1:0]      pat_o,
  output logic                   busy_o,
  output logic                   done_o
);
  logic rst_n_s;
  logic aux_s, aux_prev, aux_rise;
  logic rd_en;

  // Reset: asserted asynchronously, released on the clock
  patseq_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  patseq_sync #(.STAGES(2)) u_aux_sync (
    .clk(clk), .rst_n(rst_n_s), .d(aux_i), .q(aux_s)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) aux_prev <= 1'b0;
    else          aux_prev <= aux_s;
  end

  assign aux_rise = aux_s & ~aux_prev;

  patseq_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s),
    .start(start_i | aux_rise),
    .blk_base(blk_base_i), .blk_len(blk_len_i),
    .last_blk(last_blk_i), .loop_first(loop_first_i), .loop_last(loop_last_i),
    .loop_cnt(loop_cnt_i), .loop_inf(loop_inf_i),
    .rd_en(rd_en), .rd_addr(rd_addr_o), .blk_idx(blk_idx_o),
    .busy(busy_o), .done(done_o)
  );

  patseq_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n_s),
    .we(wr_en_i), .waddr(wr_addr_i), .wdata(wr_data_i),
    .re(rd_en), .raddr(rd_addr_o), .rdata(pat_o)
  );
endmodule

// File: rtl/patseq_chk.sv
module patseq_chk #(
  parameter int WORD_W = 512,
  parameter int ADDR_W = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy_o,
  input logic                  done_o,
  input logic [WORD_W-1:0]     pat_o,
  input logic [1:0]            blk_idx_o,
  input logic [ADDR_W-1:0]     rd_addr_o,
  input logic [4*ADDR_W-1:0]   blk_base_i
);
  logic [ADDR_W-1:0] cur_base;
  assign cur_base = blk_base_i[blk_idx_o*ADDR_W +: ADDR_W];

  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  assert_done_with_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $fell(busy_o));

  assert_idle_data_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> (pat_o == '0));

  assert_start_block0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (blk_idx_o == '0));

  // Inside a block, successive words sit at successive addresses
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && $stable(blk_idx_o) && rd_addr_o != '0 &&
     $past(rd_addr_o) != '0 && rd_addr_o != cur_base)
    |-> (rd_addr_o == ADDR_W'($past(rd_addr_o) + 1'b1)));
endmodule

bind patseq_top patseq_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o), .pat_o(pat_o),
  .blk_idx_o(blk_idx_o), .rd_addr_o(rd_addr_o), .blk_base_i(blk_base_i)
);

// File: tb/patseq_top_test.sv
module patseq_top_test;
  localparam int WW  = 16;
  localparam int DEP = 32;
  localparam int LW  = 3;
  localparam int CW  = 2;
  localparam int AW  = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n;
  logic           wr_en_i;
  logic [AW-1:0]  wr_addr_i;
  logic [WW-1:0]  wr_data_i;
  logic [4*AW-1:0] blk_base_i;
  logic [4*LW-1:0] blk_len_i;
  logic [1:0]     last_blk_i, loop_first_i, loop_last_i;
  logic [CW-1:0]  loop_cnt_i;
  logic           loop_inf_i, start_i, aux_i;
  logic [AW-1:0]  rd_addr_o;
  logic [1:0]     blk_idx_o;
  logic [WW-1:0]  pat_o;
  logic           busy_o, done_o;

  patseq_top #(.WORD_W(WW), .DEPTH(DEP), .LEN_W(LW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .blk_base_i(blk_base_i), .blk_len_i(blk_len_i),
    .last_blk_i(last_blk_i), .loop_first_i(loop_first_i), .loop_last_i(loop_last_i),
    .loop_cnt_i(loop_cnt_i), .loop_inf_i(loop_inf_i), .start_i(start_i), .aux_i(aux_i),
    .rd_addr_o(rd_addr_o), .blk_idx_o(blk_idx_o), .pat_o(pat_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int base[4];
  int len[4];
  int lastb, lf, ll, cnt;
  bit inf;
  int ea[256];
  int eb[256];
  int ee[256];
  int elen;

  function automatic int dat(int a);
    return (a * 37 + 5) & 16'hFFFF;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply_cfg();
    for (int i = 0; i < 4; i++) begin
      blk_base_i[i*AW +: AW] = AW'(base[i]);
      blk_len_i[i*LW +: LW]  = LW'(len[i]);
    end
    last_blk_i   = 2'(lastb);
    loop_first_i = 2'(lf);
    loop_last_i  = 2'(ll);
    loop_cnt_i   = CW'(cnt);
    loop_inf_i   = inf;
  endtask

  // Expected address stream from the block list and loop rules
  task automatic build(input int cap);
    int b;
    int it;
    b = 0; it = 0; elen = 0;
    while (elen < cap) begin
      if (len[b] == 0) begin
        ea[elen] = 0; eb[elen] = b; ee[elen] = 0; elen++;
      end else begin
        for (int o = 0; o < len[b]; o++) begin
          ea[elen] = (base[b] + o) % DEP; eb[elen] = b; ee[elen] = 1; elen++;
        end
      end
      if (b == ll && (inf || it < cnt)) begin
        b = lf;
        if (!inf) it++;
      end else if (b == lastb) begin
        break;
      end else begin
        b++;
      end
    end
    if (elen > cap) elen = cap;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 pat", pat_o, 0);
    chk("R1 addr", rd_addr_o, 0);
  endtask

  task automatic run(input string tag, input bit use_aux, input bit poke);
    apply_cfg();
    build(inf ? 40 : 256);
    if (use_aux) begin
      aux_i = 1'b1;
      @(negedge clk);
      chk("R3 not yet started", busy_o, 0);
      @(negedge clk);
      chk("R3 not yet started", busy_o, 0);
      @(negedge clk);
    end else begin
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    chk("R2 done cleared", done_o, 0);
    for (int k = 0; k < elen; k++) begin
      start_i = (poke && k == 1);
      chk({tag, " busy"}, busy_o, 1);
      chk({tag, ee[k] ? " addr" : " R6 zero-length addr"}, rd_addr_o, ee[k] ? ea[k] : 0);
      chk({tag, " R11 blk"}, blk_idx_o, eb[k]);
      if (k == 0) chk({tag, " R5 first data"}, pat_o, 0);
      else        chk({tag, " R5 data"}, pat_o, ee[k-1] ? dat(ea[k-1]) : 0);
      @(negedge clk);
    end
    start_i = 1'b0;
    if (!inf) begin
      chk({tag, " R9 busy end"}, busy_o, 0);
      chk({tag, " R9 done"}, done_o, 1);
      chk({tag, " R5 last data"}, pat_o, ee[elen-1] ? dat(ea[elen-1]) : 0);
      @(negedge clk);
      chk({tag, " R9 idle data"}, pat_o, 0);
      chk({tag, " R9 idle addr"}, rd_addr_o, 0);
      repeat (2) @(negedge clk);
      chk({tag, " R9 done held"}, done_o, 1);
      chk({tag, use_aux ? " R3 held level no restart" : " R9 stay idle"}, busy_o, 0);
    end
    if (use_aux) begin
      aux_i = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    blk_base_i = '0; blk_len_i = '0; last_blk_i = '0; loop_first_i = '0;
    loop_last_i = '0; loop_cnt_i = '0; loop_inf_i = 1'b0;
    start_i = 1'b0; aux_i = 1'b0;
    do_reset();

    for (int a = 0; a < DEP; a++) begin
      wr_en_i = 1'b1; wr_addr_i = AW'(a); wr_data_i = WW'(dat(a));
      @(negedge clk);
    end
    wr_en_i = 1'b0;

    base = '{0, 8, 16, 29};
    len  = '{2, 3, 1, 4};
    inf  = 1'b0;

    // R4: plain order, every last block index
    for (int lb = 0; lb < 4; lb++) begin
      lastb = lb; lf = 0; ll = 0; cnt = 0;
      run("R4 order", 1'b0, 1'b0);
    end

    // R7: every loop range and count; R10 and R3 mixed in
    lastb = 3;
    for (int f = 0; f < 4; f++)
      for (int l = f; l < 4; l++)
        for (int c = 0; c < 4; c++) begin
          lf = f; ll = l; cnt = c;
          if (c == 1)      run("R7 loop R10 busy start", 1'b0, 1'b1);
          else if (c == 2) run("R7 loop R3 aux", 1'b1, 1'b0);
          else             run("R7 loop", 1'b0, 1'b0);
        end

    // R6: zero-length blocks inside and outside the loop
    len = '{2, 0, 0, 1};
    lastb = 3; lf = 1; ll = 2; cnt = 1;
    run("R6 zero", 1'b0, 1'b0);
    len = '{0, 3, 0, 2};
    lf = 0; ll = 3; cnt = 2;
    run("R6 zero", 1'b1, 1'b0);

    // R8: endless loop
    len = '{2, 3, 1, 2};
    lastb = 3; lf = 1; ll = 2; cnt = 0; inf = 1'b1;
    run("R8 endless", 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    chk("R8 still busy", busy_o, 1);
    chk("R8 never done", done_o, 0);
    inf = 1'b0;
    do_reset();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule